// File: doc/BRIEF.md
# Microcoded 8-bit ALU with carry and zero flags

This block is the arithmetic and logic datapath of a small microcoded processor. Each cycle the sequencer presents a set of independent control bits together with a left and a right operand that have already been selected upstream. The block returns a combinational result, used both for register write-back and as store data. It also keeps two flag flip-flops: a carry flag and a zero flag.

Operations are composed from orthogonal bits rather than from an opcode. One adder serves plain add, add-with-carry, subtract, subtract-with-borrow, compare, increment, decrement, test and move. The choice depends on whether the left operand is gated in, whether the right operand is inverted, and where the carry-in comes from. The convention is that a set carry after a subtraction means no borrow occurred. Bitwise operations and shifts update only the zero flag. A separate load strobe lets memory-load paths set the zero flag from a fetched byte.

Register storage, operand muxing and memory access sit outside the block. All operand and flag widths follow the parameter `W` (default 8). There is no streaming data interface: operands and the result are plain per-cycle signals, and every pin is a level.

Top module: `ucode_alu`

## Requirements
- R1: The adder computes `L' + R' + cin` modulo 2^W. `L'` is the left operand when `run` is 1 and zero otherwise. `R'` is the right operand, bit-inverted when `inv_rhs` is 1. `cin = cin_one | (cin_flag & carry_flag)`. The adder carry-out is bit W of that sum.
- R2: Subtraction (`run`, `inv_rhs`, `cin_one`) yields `L - R` modulo 2^W. Its carry-out is 1 exactly when `L >= R` (carry set means no borrow).
- R3: With `cin_flag` set and `cin_one` clear, the stored carry flag is the carry-in. This gives add-with-carry (`L + R + CF`) and subtract-with-carry (`L + ~R + CF`).
- R4: `and_en`, `or_en` and `xor_en` give `L' & R'`, `L' | R'` and `L' ^ R'`. With `inv_rhs`, the and form is `L & ~R`. These operations never change the carry flag unless `save_carry` is set.
- R5: With `shift_en` the left operand (ungated by `run`) is shifted by the amount given by the whole right operand. The direction is set by `shift_right` (0 left, 1 right). `roll_en` selects rotation, and `arith_en` selects sign fill on right shifts.
- R6: For amounts of W or more, a logical shift yields 0 and an arithmetic right shift yields W copies of the sign bit. A rotation uses the amount modulo W.
- R7: Result source priority is shift, then and, then or, then xor, then adder (`add_en`). With none of these set, the result is 0. A move is `add_en` with `run` clear, and it returns the right operand.
- R8: On a rising clock edge, the carry flag takes the adder carry-out only when `save_carry` is 1, and holds otherwise.
- R9: On a rising edge with `save_zero` set, the zero flag becomes 1 if the result is 0 and 0 otherwise. With neither `save_zero` nor `ld_zero_stb` set, it holds.
- R10: `ld_zero_stb` loads the zero flag from `ld_byte == 0` and never touches the carry flag. When it coincides with `save_zero`, the strobe wins.
- R11: Synchronous reset (`rst` high at a rising edge) clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Gate the left operand into adder and logic unit |
| add_en | input | 1 | Select adder output |
| inv_rhs | input | 1 | Invert right operand for adder and logic unit |
| cin_one | input | 1 | Force adder carry-in to 1 |
| cin_flag | input | 1 | Use stored carry flag as carry-in |
| and_en | input | 1 | Select bitwise and |
| or_en | input | 1 | Select bitwise or |
| xor_en | input | 1 | Select bitwise xor |
| shift_en | input | 1 | Select shift unit |
| shift_right | input | 1 | Shift direction right |
| roll_en | input | 1 | Rotate instead of shift |
| arith_en | input | 1 | Sign fill on right shift |
| save_carry | input | 1 | Capture adder carry into carry flag |
| save_zero | input | 1 | Capture result-is-zero into zero flag |
| lhs | input | W | Left operand |
| rhs | input | W | Right operand / shift amount |
| ld_zero_stb | input | 1 | Update zero flag from loaded byte |
| ld_byte | input | W | Byte returned by a memory load |
| result | output | W | Combinational result |
| carry_flag | output | 1 | Stored carry flag |
| zero_flag | output | 1 | Stored zero flag (1 = last saved value was zero) |

## Verification
The bench targets subtract and compare at equal, larger and smaller operands. An inverted carry convention would flip the flag exactly at those borders. Carry-chained operations are run both with the flag set and with it clear, which exposes a carry-in taken from the wrong source. Shifts are driven at amounts 0, W-1, W and 255 with negative operands, so that a shifter which wraps logical amounts, loses the sign fill or fails to reduce rotates modulo W gives a visibly wrong byte. Flag-hold cases interleave logic operations, loads and a simultaneous load plus save, which reveals a carry clobbered by a logic op or a wrong priority between the two zero-flag sources.

// File: rtl/ucode_alu_pkg.sv
package ucode_alu_pkg;

  // Individual microcode control bits, gathered once at the top.
  typedef struct packed {
    logic run;
    logic add_en;
    logic inv_rhs;
    logic cin_one;
    logic cin_flag;
    logic and_en;
    logic or_en;
    logic xor_en;
    logic shift_en;
    logic shift_right;
    logic roll_en;
    logic arith_en;
    logic save_carry;
    logic save_zero;
  } alu_ctrl_t;

  // Result source after priority resolution.
  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_ADD   = 3'd1,
    SRC_XOR   = 3'd2,
    SRC_OR    = 3'd3,
    SRC_AND   = 3'd4,
    SRC_SHIFT = 3'd5
  } res_src_e;

  function automatic res_src_e pick_source(input alu_ctrl_t c);
    if (c.shift_en)    return SRC_SHIFT;
    else if (c.and_en) return SRC_AND;
    else if (c.or_en)  return SRC_OR;
    else if (c.xor_en) return SRC_XOR;
    else if (c.add_en) return SRC_ADD;
    else               return SRC_NONE;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] and_out,
  output logic [W-1:0] or_out,
  output logic [W-1:0] xor_out
);
  always_comb begin
    and_out = a_in & b_in;
    or_out  = a_in | b_in;
    xor_out = a_in ^ b_in;
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] amount,
  input  logic         go_right,
  input  logic         rotate,
  input  logic         arith,
  output logic [W-1:0] data_out
);
  localparam int SHW = $clog2(W);

  logic             sign_bit;
  logic             over_range;
  logic [W-1:0]     stg [0:SHW];

  assign sign_bit = data_in[W-1];
  assign stg[0]   = data_in;

  // Amount bits above the log2 range make any non-rotating shift saturate.
  generate
    if (W > SHW) begin : g_over
      assign over_range = |amount[W-1:SHW];
    end else begin : g_noover
      assign over_range = 1'b0;
    end
  endgenerate

  // Logarithmic barrel: stage k moves by 2**k positions.
  generate
    for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [W-1:0] to_left;
      logic [W-1:0] to_right;
      logic [S-1:0] fill_l;
      logic [S-1:0] fill_r;

      always_comb begin
        fill_l = rotate ? stg[k][W-1:W-S] : '0;
        if (rotate)     fill_r = stg[k][S-1:0];
        else if (arith) fill_r = {S{sign_bit}};
        else            fill_r = '0;
      end

      assign to_left  = {stg[k][W-S-1:0], fill_l};
      assign to_right = {fill_r, stg[k][W-1:S]};
      assign stg[k+1] = amount[k] ? (go_right ? to_right : to_left) : stg[k];
    end
  endgenerate

  always_comb begin
    if (over_range && !rotate)
      data_out = (go_right && arith) ? {W{sign_bit}} : '0;
    else
      data_out = stg[SHW];
  end
endmodule

// File: rtl/alu_flag_regs.sv
module alu_flag_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         save_carry,
  input  logic         save_zero,
  input  logic         carry_in,
  input  logic [W-1:0] res_in,
  input  logic         ld_stb,
  input  logic [W-1:0] ld_val,
  output logic         cf_q,
  output logic         zf_q
);
  logic cf_d;
  logic zf_d;

  always_comb begin
    cf_d = save_carry ? carry_in : cf_q;
    if (ld_stb)         zf_d = (ld_val == '0);
    else if (save_zero) zf_d = (res_in == '0);
    else                zf_d = zf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cf_q <= 1'b0;
      zf_q <= 1'b0;
    end else begin
      cf_q <= cf_d;
      zf_q <= zf_d;
    end
  end
endmodule

// File: rtl/ucode_alu.sv
module ucode_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         add_en,
  input  logic         inv_rhs,
  input  logic         cin_one,
  input  logic         cin_flag,
  input  logic         and_en,
  input  logic         or_en,
  input  logic         xor_en,
  input  logic         shift_en,
  input  logic         shift_right,
  input  logic         roll_en,
  input  logic         arith_en,
  input  logic         save_carry,
  input  logic         save_zero,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         ld_zero_stb,
  input  logic [W-1:0] ld_byte,
  output logic [W-1:0] result,
  output logic         carry_flag,
  output logic         zero_flag
);
  import ucode_alu_pkg::*;

  alu_ctrl_t    ctl;
  res_src_e     src;
  logic [W-1:0] l_gated;
  logic [W-1:0] r_eff;
  logic         carry_in;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] and_r, or_r, xor_r;
  logic [W-1:0] sh_r;

  assign ctl = '{run: run, add_en: add_en, inv_rhs: inv_rhs, cin_one: cin_one,
                 cin_flag: cin_flag, and_en: and_en, or_en: or_en, xor_en: xor_en,
                 shift_en: shift_en, shift_right: shift_right, roll_en: roll_en,
                 arith_en: arith_en, save_carry: save_carry, save_zero: save_zero};

  assign l_gated  = ctl.run ? lhs : '0;
  assign r_eff    = ctl.inv_rhs ? ~rhs : rhs;
  assign carry_in = ctl.cin_one | (ctl.cin_flag & carry_flag);
  assign src      = pick_source(ctl);

  alu_addsub #(.W(W)) u_add (
    .a_in (l_gated),
    .b_in (r_eff),
    .cin  (carry_in),
    .sum  (add_sum),
    .cout (add_cout)
  );

  alu_logic #(.W(W)) u_logic (
    .a_in    (l_gated),
    .b_in    (r_eff),
    .and_out (and_r),
    .or_out  (or_r),
    .xor_out (xor_r)
  );

  alu_shifter #(.W(W)) u_shift (
    .data_in  (lhs),
    .amount   (rhs),
    .go_right (ctl.shift_right),
    .rotate   (ctl.roll_en),
    .arith    (ctl.arith_en),
    .data_out (sh_r)
  );

  always_comb begin
    unique case (src)
      SRC_SHIFT: result = sh_r;
      SRC_AND:   result = and_r;
      SRC_OR:    result = or_r;
      SRC_XOR:   result = xor_r;
      SRC_ADD:   result = add_sum;
      default:   result = '0;
    endcase
  end

  alu_flag_regs #(.W(W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .save_carry (ctl.save_carry),
    .save_zero  (ctl.save_zero),
    .carry_in   (add_cout),
    .res_in     (result),
    .ld_stb     (ld_zero_stb),
    .ld_val     (ld_byte),
    .cf_q       (carry_flag),
    .zf_q       (zero_flag)
  );
endmodule

// File: rtl/ucode_alu_chk.sv
module ucode_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         add_en,
  input logic         inv_rhs,
  input logic         cin_one,
  input logic         cin_flag,
  input logic         and_en,
  input logic         or_en,
  input logic         xor_en,
  input logic         shift_en,
  input logic         shift_right,
  input logic         roll_en,
  input logic         arith_en,
  input logic         save_carry,
  input logic         save_zero,
  input logic [W-1:0] lhs,
  input logic [W-1:0] rhs,
  input logic         ld_zero_stb,
  input logic [W-1:0] ld_byte,
  input logic [W-1:0] result,
  input logic         carry_flag,
  input logic         zero_flag
);
  logic move_op;
  assign move_op = add_en & ~run & ~inv_rhs & ~cin_one & ~cin_flag &
                   ~and_en & ~or_en & ~xor_en & ~shift_en;

  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !save_carry |=> $stable(carry_flag)); // R8

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!save_zero && !ld_zero_stb) |=> $stable(zero_flag)); // R9

  AST_ZERO_SAVE: assert property (@(posedge clk) disable iff (rst)
    (save_zero && !ld_zero_stb) |=> (zero_flag == ($past(result) == '0))); // R9

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ld_zero_stb |=> (zero_flag == ($past(ld_byte) == '0))); // R10

  AST_MOVE_PASS: assert property (@(posedge clk) disable iff (rst)
    move_op |-> (result == rhs)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!add_en && !and_en && !or_en && !xor_en && !shift_en) |-> (result == '0)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!carry_flag && !zero_flag)); // R11
endmodule

bind ucode_alu ucode_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_ucode_alu.sv
`timescale 1ns/1ps
module sim_ucode_alu;
  localparam int B_RUN = 0, B_ADD = 1, B_INV = 2, B_C1 = 3, B_CF = 4,
                 B_AND = 5, B_OR = 6, B_XOR = 7, B_SH = 8, B_SR = 9,
                 B_ROL = 10, B_AR = 11, B_SC = 12, B_SZ = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] c = '0;
  logic [7:0] lhs = '0, rhs = '0, ld_byte = '0;
  logic ld_zero_stb = 1'b0;
  logic [7:0] result;
  logic carry_flag, zero_flag;

  int total = 0;
  int bad = 0;
  logic m_cf = 1'b0, m_zf = 1'b0;

  always #4 clk = ~clk;

  ucode_alu u0 (
    .clk(clk), .rst(rst), .run(c[B_RUN]), .add_en(c[B_ADD]), .inv_rhs(c[B_INV]),
    .cin_one(c[B_C1]), .cin_flag(c[B_CF]), .and_en(c[B_AND]), .or_en(c[B_OR]),
    .xor_en(c[B_XOR]), .shift_en(c[B_SH]), .shift_right(c[B_SR]),
    .roll_en(c[B_ROL]), .arith_en(c[B_AR]), .save_carry(c[B_SC]),
    .save_zero(c[B_SZ]), .lhs(lhs), .rhs(rhs), .ld_zero_stb(ld_zero_stb),
    .ld_byte(ld_byte), .result(result), .carry_flag(carry_flag),
    .zero_flag(zero_flag)
  );

  // Expected {carry_out, result} from the requirements.
  function automatic logic [8:0] model(input logic [13:0] k, input logic [7:0] l,
                                       input logic [7:0] r, input logic cf);
    logic [7:0] a, b, res;
    logic [8:0] s;
    logic [15:0] dbl;
    logic signed [7:0] sl;
    int n;
    a = k[B_RUN] ? l : 8'h00;
    b = k[B_INV] ? ~r : r;
    s = {1'b0, a} + {1'b0, b} + {8'h00, (k[B_C1] | (k[B_CF] & cf))};
    if (k[B_SH]) begin
      if (k[B_ROL]) begin
        n = int'(r) % 8;
        dbl = {l, l};
        if (k[B_SR]) begin dbl = dbl >> n; res = dbl[7:0]; end
        else begin dbl = dbl << n; res = dbl[15:8]; end
      end else if (k[B_SR] && k[B_AR]) begin
        sl = $signed(l);
        res = (r >= 8) ? {8{l[7]}} : 8'(sl >>> r);
      end else if (k[B_SR]) res = (r >= 8) ? 8'h00 : (l >> r);
      else res = (r >= 8) ? 8'h00 : 8'(l << r);
    end
    else if (k[B_AND]) res = a & b;
    else if (k[B_OR])  res = a | b;
    else if (k[B_XOR]) res = a ^ b;
    else if (k[B_ADD]) res = s[7:0];
    else res = 8'h00;
    return {s[8], res};
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change at a falling edge; result sampled 1 ns later, flags one edge on.
  task automatic step(input logic [13:0] k, input logic [7:0] l, input logic [7:0] r,
                      input logic ld, input logic [7:0] lb, input string req);
    logic [8:0] e;
    c = k; lhs = l; rhs = r; ld_zero_stb = ld; ld_byte = lb;
    #1;
    e = model(k, l, r, m_cf);
    chk({req, " result"}, {1'b0, result}, {1'b0, e[7:0]});
    @(posedge clk);
    if (k[B_SC]) m_cf = e[8];
    if (ld) m_zf = (lb == 8'h00);
    else if (k[B_SZ]) m_zf = (e[7:0] == 8'h00);
    @(negedge clk);
    chk({req, " flags"}, {7'd0, carry_flag, zero_flag}, {7'd0, m_cf, m_zf});
  endtask

  function automatic logic [13:0] op(input int kind);
    logic [13:0] k = '0;
    case (kind)
      0: begin k[B_RUN]=1; k[B_ADD]=1; k[B_SC]=1; k[B_SZ]=1; end                  // add
      1: begin k[B_RUN]=1; k[B_ADD]=1; k[B_INV]=1; k[B_C1]=1; k[B_SC]=1; k[B_SZ]=1; end // sub
      2: begin k[B_RUN]=1; k[B_ADD]=1; k[B_CF]=1; k[B_SC]=1; k[B_SZ]=1; end       // adc
      3: begin k[B_RUN]=1; k[B_ADD]=1; k[B_INV]=1; k[B_CF]=1; k[B_SC]=1; k[B_SZ]=1; end // sbc
      4: begin k[B_RUN]=1; k[B_AND]=1; k[B_SZ]=1; end
      5: begin k[B_RUN]=1; k[B_OR]=1; k[B_SZ]=1; end
      6: begin k[B_RUN]=1; k[B_XOR]=1; k[B_SZ]=1; end
      7: begin k[B_RUN]=1; k[B_AND]=1; k[B_INV]=1; k[B_SZ]=1; end                 // and-not
      8: begin k[B_SH]=1; k[B_SZ]=1; end
      9: begin k[B_SH]=1; k[B_SR]=1; k[B_SZ]=1; end
      10: begin k[B_SH]=1; k[B_ROL]=1; k[B_SZ]=1; end
      11: begin k[B_SH]=1; k[B_SR]=1; k[B_ROL]=1; k[B_SZ]=1; end
      12: begin k[B_SH]=1; k[B_SR]=1; k[B_AR]=1; k[B_SZ]=1; end
      13: begin k[B_ADD]=1; k[B_SZ]=1; end                                        // move
      default: begin k[B_RUN]=1; k[B_ADD]=1; k[B_C1]=1; k[B_SC]=1; k[B_SZ]=1; end // inc
    endcase
    return k;
  endfunction

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED_A1B2));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset", {7'd0, carry_flag, zero_flag}, 9'd0);
    rst = 1'b0;

    step(op(0), 8'hF0, 8'h10, 0, 0, "R1 add wrap");
    step(op(1), 8'h42, 8'h42, 0, 0, "R2 sub equal");
    step(op(1), 8'h10, 8'h11, 0, 0, "R2 sub borrow");
    step(op(1), 8'h80, 8'h01, 0, 0, "R2 sub no borrow");
    step(op(1) & ~(14'd1 << B_SC), 8'h00, 8'h00, 0, 0, "R8 no carry save");
    step(op(0), 8'hFF, 8'h01, 0, 0, "R1 set carry");
    step(op(2), 8'h05, 8'h06, 0, 0, "R3 adc with CF");
    step(op(3), 8'h09, 8'h04, 0, 0, "R3 sbc CF clear");
    step(op(3), 8'h09, 8'h04, 0, 0, "R3 sbc CF set");
    step(op(7), 8'hFF, 8'h0F, 0, 0, "R4 and-not");
    step(op(4), 8'hAA, 8'h55, 0, 0, "R4 and zero keeps carry");
    step(op(8), 8'h81, 8'd1, 0, 0, "R5 shl 1");
    step(op(9), 8'h81, 8'd7, 0, 0, "R5 shr 7");
    step(op(8), 8'h81, 8'd8, 0, 0, "R6 shl 8");
    step(op(9), 8'hFF, 8'd255, 0, 0, "R6 shr 255");
    step(op(12), 8'h90, 8'd3, 0, 0, "R5 sra 3");
    step(op(12), 8'h90, 8'd200, 0, 0, "R6 sra big");
    step(op(12), 8'h70, 8'd9, 0, 0, "R6 sra big positive");
    step(op(10), 8'h81, 8'd9, 0, 0, "R6 rol 9");
    step(op(11), 8'h81, 8'd8, 0, 0, "R6 ror 8");
    step(op(11), 8'h03, 8'd1, 0, 0, "R5 ror 1");
    step(op(13), 8'h33, 8'hC4, 0, 0, "R7 move");
    step(op(13) | op(4), 8'hF0, 8'h3C, 0, 0, "R7 and over add");
    step(op(8) | op(6), 8'h01, 8'd2, 0, 0, "R7 shift over xor");
    step(14'd1 << B_SZ, 8'h77, 8'h66, 0, 0, "R7 no source");
    step(14'd0, 8'h00, 8'h00, 1, 8'h00, "R10 load zero");
    step(op(0), 8'h01, 8'h01, 1, 8'h00, "R10 load wins");
    step(14'd0, 8'h00, 8'h00, 1, 8'h5A, "R10 load nonzero");
    step(op(0), 8'h80, 8'h80, 0, 0, "R9 save zero");
    step(14'd0, 8'h12, 8'h34, 0, 0, "R9 hold");

    for (int i = 0; i < 400; i++) begin
      int kind;
      logic [7:0] l, r;
      kind = int'($urandom_range(0, 14));
      l = 8'($urandom);
      r = 8'($urandom);
      if (kind >= 8 && kind <= 12 && ($urandom_range(0, 3) != 0)) r = 8'($urandom_range(0, 9));
      step(op(kind), l, r, ($urandom_range(0, 9) == 0), 8'($urandom_range(0, 3)),
           "R1 random mix");
    end

    @(posedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; m_cf = 0; m_zf = 0;
    chk("R11 mid reset", {7'd0, carry_flag, zero_flag}, 9'd0);
    finish_up();
  end
endmodule